// File: doc/BRIEF.md
# Vector length state register unit

This block keeps the 32-bit vector-state word of a scalar-issue vector loop engine. The word packs the maximum length, the active length, the sub-vector group size and three loop position counters. The block takes CSR-style writes through a selector. Each selector value starts a different update: set the active length, set the maximum length, set the group size, or load the whole word. Writes to a length clamp the value into its legal range. A set-length write reports the length actually granted. A group-size write outside 1..4 is refused and flagged.

Both lengths are stored minus one, so a 6-bit field spans 1..64. When a trap is taken or returned from, the live word and one saved copy trade places, so that a handler gets its own loop context and the interrupted context comes back intact. All inputs are plain control pins. A write takes effect at the clock edge where `wr_en` is sampled high. No stream interface is involved, so there is no back-pressure.

Top module: `vstate_csr_unit`

## Requirements
- R1: After reset the state word reads 0. Maximum length, active length and group size all decode as 1, the offsets are 0, `granted_vl` is 1 and `subvl_err` is 0.
- R2: Selector 0 requests the active length `wr_data`. The unit grants 1 for a request of 0, the maximum length for a request above it, and the request itself otherwise. It stores the grant minus one in bits 11:6 and shows the grant on `granted_vl` from the next cycle.
- R3: Selector 1 is the immediate form of selector 0. The request is `wr_data[4:0]+1`, and the upper data bits are ignored.
- R4: Selector 2 requests the maximum length `wr_data`, clamped to 1..XLEN and stored minus one in bits 5:0. If the active length now exceeds the new maximum, it is lowered to that maximum.
- R5: Selector 3 is the immediate form of selector 2, with the request `wr_data[4:0]+1`.
- R6: Selector 4 sets the group size. A value of 1 to 4 is stored in bits 25:24 as the value minus one. Any other value leaves the word unchanged and raises `subvl_err` for exactly one cycle.
- R7: Selector 5 loads the whole word. The fields are maxvl 5:0, vl 11:6, srcoffs 17:12, destoffs 23:18, subvl 25:24 and dsvoffs 27:26. If the loaded vl field is greater than the maxvl field, vl is truncated to maxvl.
- R8: Bits 31:28 always read zero, whatever is written.
- R9: A pulse on `trap_enter` or `trap_return` exchanges the live word with the saved copy, which is 0 after reset. A write in the same cycle is discarded.
- R10: Selectors 6 and 7 have no effect on the word.
- R11: The active length never exceeds the maximum length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write selector (0..5 used) |
| wr_data | input | 32 | Write data |
| trap_enter | input | 1 | Swap live and saved word on trap entry |
| trap_return | input | 1 | Swap live and saved word on trap return |
| state_rd | output | 32 | Full state word |
| maxvl_len | output | 7 | Decoded maximum length, 1..64 |
| vl_len | output | 7 | Decoded active length, 1..64 |
| subvl_len | output | 3 | Decoded group size, 1..4 |
| srcoffs | output | 6 | Source element offset |
| destoffs | output | 6 | Destination element offset |
| dsvoffs | output | 2 | Sub-vector destination offset |
| granted_vl | output | 7 | Length granted by the last set-length write |
| subvl_err | output | 1 | One-cycle flag for a refused group size |

## Verification
Every field is a register that reads straight out to the ports, so any corrupted state shows on `state_rd` and the decoded outputs one cycle after the write that caused it. A wrong clamp shows up as an active length above the maximum, or as a `granted_vl` that differs from the stored field. A wrong swap returns the wrong word on the very next cycle after a trap strobe. The sweeps cover every request around each clamp edge, so an off-by-one in the stored-minus-one encoding breaks the length outputs on the first request that reaches it.

// File: rtl/vstate_pkg.sv
package vstate_pkg;
  localparam int FW = 6;

  typedef enum logic [2:0] {
    SEL_VL      = 3'd0,
    SEL_VL_IMM  = 3'd1,
    SEL_MVL     = 3'd2,
    SEL_MVL_IMM = 3'd3,
    SEL_SUBVL   = 3'd4,
    SEL_STATE   = 3'd5
  } vsel_e;

  typedef struct packed {
    logic [3:0]    rsvd;
    logic [1:0]    dsvoffs;
    logic [1:0]    subvl;
    logic [FW-1:0] destoffs;
    logic [FW-1:0] srcoffs;
    logic [FW-1:0] vl;
    logic [FW-1:0] maxvl;
  } vstate_t;
endpackage

// File: rtl/vstate_len_clamp.sv
module vstate_len_clamp #(
  parameter int REQW = 32,
  parameter int LENW = 7
) (
  input  logic [REQW-1:0] req,
  input  logic [LENW-1:0] limit,
  output logic [LENW-2:0] enc
);
  logic [LENW-1:0] len;
  logic [LENW-1:0] len_m1;

  always_comb begin
    if (req == '0)                 len = LENW'(1);
    else if (req > REQW'(limit))   len = limit;
    else                           len = req[LENW-1:0];
  end

  assign len_m1 = len - LENW'(1);
  assign enc    = len_m1[LENW-2:0];
endmodule

// File: rtl/vstate_next.sv
module vstate_next
  import vstate_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  vstate_t     cur,
  input  logic        wr_en,
  input  logic [2:0]  wr_sel,
  input  logic [31:0] wr_data,
  output vstate_t     nxt,
  output logic        grant_we,
  output logic        subvl_err
);
  localparam int LENW = $clog2(XLEN) + 1;
  localparam logic [FW-1:0] MAXF = FW'(XLEN - 1);

  logic [31:0]     imm_req, req;
  logic            imm_form;
  logic [LENW-1:0] cur_mvl_len;
  logic [LENW-2:0] vl_enc, mvl_enc;
  logic [FW-1:0]   mvl_fld;
  vstate_t         ld;

  assign imm_form    = (wr_sel == SEL_VL_IMM) || (wr_sel == SEL_MVL_IMM);
  assign imm_req     = {27'd0, wr_data[4:0]} + 32'd1;
  assign req         = imm_form ? imm_req : wr_data;
  assign cur_mvl_len = LENW'(cur.maxvl) + LENW'(1);
  assign mvl_fld     = FW'(mvl_enc);

  vstate_len_clamp #(.REQW(32), .LENW(LENW)) u_vl_clamp (
    .req(req), .limit(cur_mvl_len), .enc(vl_enc)
  );

  vstate_len_clamp #(.REQW(32), .LENW(LENW)) u_mvl_clamp (
    .req(req), .limit(LENW'(XLEN)), .enc(mvl_enc)
  );

  always_comb begin
    ld      = vstate_t'(wr_data);
    ld.rsvd = '0;
    if (ld.maxvl > MAXF) ld.maxvl = MAXF;
    if (ld.vl > ld.maxvl) ld.vl = ld.maxvl;
  end

  always_comb begin
    nxt       = cur;
    grant_we  = 1'b0;
    subvl_err = 1'b0;
    if (wr_en) begin
      case (wr_sel)
        SEL_VL, SEL_VL_IMM: begin
          nxt.vl   = FW'(vl_enc);
          grant_we = 1'b1;
        end
        SEL_MVL, SEL_MVL_IMM: begin
          nxt.maxvl = mvl_fld;
          if (cur.vl > mvl_fld) nxt.vl = mvl_fld;
        end
        SEL_SUBVL: begin
          if (wr_data >= 32'd1 && wr_data <= 32'd4)
            nxt.subvl = wr_data[1:0] - 2'd1;
          else
            subvl_err = 1'b1;
        end
        SEL_STATE: nxt = ld;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vstate_csr_unit.sv
module vstate_csr_unit
  import vstate_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [2:0]             wr_sel,
  input  logic [31:0]            wr_data,
  input  logic                   trap_enter,
  input  logic                   trap_return,
  output logic [31:0]            state_rd,
  output logic [$clog2(XLEN):0]  maxvl_len,
  output logic [$clog2(XLEN):0]  vl_len,
  output logic [2:0]             subvl_len,
  output logic [5:0]             srcoffs,
  output logic [5:0]             destoffs,
  output logic [1:0]             dsvoffs,
  output logic [$clog2(XLEN):0]  granted_vl,
  output logic                   subvl_err
);
  localparam int LENW = $clog2(XLEN) + 1;

  vstate_t         state_q, shadow_q, nxt;
  logic            grant_we, err_d, err_q, swap;
  logic [LENW-1:0] grant_q;

  assign swap = trap_enter | trap_return;

  vstate_next #(.XLEN(XLEN)) u_next (
    .cur(state_q), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .nxt(nxt), .grant_we(grant_we), .subvl_err(err_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= '0;
      shadow_q <= '0;
      grant_q  <= LENW'(1);
      err_q    <= 1'b0;
    end else if (swap) begin
      state_q  <= shadow_q;
      shadow_q <= state_q;
      err_q    <= 1'b0;
    end else begin
      state_q <= nxt;
      err_q   <= err_d;
      if (grant_we) grant_q <= LENW'(nxt.vl) + LENW'(1);
    end
  end

  assign state_rd   = state_q;
  assign maxvl_len  = LENW'(state_q.maxvl) + LENW'(1);
  assign vl_len     = LENW'(state_q.vl) + LENW'(1);
  assign subvl_len  = {1'b0, state_q.subvl} + 3'd1;
  assign srcoffs    = state_q.srcoffs;
  assign destoffs   = state_q.destoffs;
  assign dsvoffs    = state_q.dsvoffs;
  assign granted_vl = grant_q;
  assign subvl_err  = err_q;

  a_r11_vl_within_mvl: assert property (@(posedge clk) disable iff (!rst_n)
    vl_len <= maxvl_len);

  a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    state_rd[31:28] == 4'd0);

  a_r6_bad_subvl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !swap && wr_sel == SEL_SUBVL && (wr_data == 32'd0 || wr_data > 32'd4))
    |=> (subvl_err && $stable(state_rd)));

  a_r9_swap_loads_saved: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (state_rd == $past(shadow_q)));

  a_r2_grant_matches_vl: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !swap && (wr_sel == SEL_VL || wr_sel == SEL_VL_IMM))
    |=> (granted_vl == vl_len));

  a_r10_unused_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !swap && wr_sel > 3'd5) |=> $stable(state_rd));
endmodule

// File: tb/tb_vstate_csr_unit.sv
module tb_vstate_csr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic        trap_enter = 1'b0;
  logic        trap_return = 1'b0;
  logic [31:0] state_rd;
  logic [6:0]  maxvl_len, vl_len, granted_vl;
  logic [2:0]  subvl_len;
  logic [5:0]  srcoffs, destoffs;
  logic [1:0]  dsvoffs;
  logic        subvl_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] exp_st = 32'd0;
  logic [31:0] exp_sh = 32'd0;
  int          exp_grant = 1;
  bit          exp_err = 0;

  always #10 clk = ~clk;

  vstate_csr_unit #(.XLEN(64)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .trap_enter(trap_enter), .trap_return(trap_return), .state_rd(state_rd),
    .maxvl_len(maxvl_len), .vl_len(vl_len), .subvl_len(subvl_len),
    .srcoffs(srcoffs), .destoffs(destoffs), .dsvoffs(dsvoffs),
    .granted_vl(granted_vl), .subvl_err(subvl_err)
  );

  task automatic chk(string tag, longint act, longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic check_all(string tag);
    chk({tag, " word"}, state_rd, exp_st);
    chk({tag, " maxvl_len"}, maxvl_len, exp_st[5:0] + 1);
    chk({tag, " vl_len"}, vl_len, exp_st[11:6] + 1);
    chk({tag, " subvl_len"}, subvl_len, exp_st[25:24] + 1);
    chk({tag, " srcoffs"}, srcoffs, exp_st[17:12]);
    chk({tag, " destoffs"}, destoffs, exp_st[23:18]);
    chk({tag, " dsvoffs"}, dsvoffs, exp_st[27:26]);
    chk({tag, " granted_vl"}, granted_vl, exp_grant);
    chk({tag, " subvl_err"}, subvl_err, exp_err);
  endtask

  // Expected-state model built from the requirement text
  task automatic model(int sel, logic [31:0] d);
    longint req, mvl, vl, g;
    logic [31:0] s;
    mvl = exp_st[5:0] + 1;
    vl  = exp_st[11:6] + 1;
    req = (sel == 1 || sel == 3) ? longint'(d[4:0]) + 1 : longint'(d);
    exp_err = 0;
    case (sel)
      0, 1: begin
        g = (req == 0) ? 1 : ((req > mvl) ? mvl : req);
        exp_st[11:6] = 6'(g - 1);
        exp_grant = int'(g);
      end
      2, 3: begin
        g = (req == 0) ? 1 : ((req > 64) ? 64 : req);
        exp_st[5:0] = 6'(g - 1);
        if (vl > g) exp_st[11:6] = 6'(g - 1);
      end
      4: begin
        if (d >= 1 && d <= 4) exp_st[25:24] = 2'(d - 1);
        else exp_err = 1;
      end
      5: begin
        s = d;
        s[31:28] = 4'd0;
        if (s[11:6] > s[5:0]) s[11:6] = s[5:0];
        exp_st = s;
      end
      default: ;
    endcase
  endtask

  task automatic wr(int sel, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model(sel, d);
  endtask

  task automatic trap(bit ret, bit with_wr);
    @(negedge clk);
    trap_enter = !ret; trap_return = ret;
    wr_en = with_wr; wr_sel = 3'd5; wr_data = 32'h0ABC_DEF1;
    @(negedge clk);
    trap_enter = 1'b0; trap_return = 1'b0; wr_en = 1'b0;
    begin
      logic [31:0] t;
      t = exp_st; exp_st = exp_sh; exp_sh = t;
    end
    exp_err = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    int mv[4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R4 maximum length sweep, R11 holds along the way
    wr(0, 32'd64);
    for (int r = 0; r <= 70; r++) begin
      wr(2, 32'(r));
      check_all("R4 setmvl");
      wr(0, 32'd100);
    end
    wr(2, 32'hFFFF_FFFF);
    check_all("R4 setmvl huge");

    // R2 active length sweep at several maxima
    mv = '{1, 7, 32, 64};
    foreach (mv[k]) begin
      wr(2, 32'(mv[k]));
      for (int r = 0; r <= 70; r++) begin
        wr(0, 32'(r));
        check_all("R2 setvl");
      end
      wr(0, 32'hFFFF_FFFF);
      check_all("R2 setvl huge");
    end

    // R3 immediate set-length with junk in upper bits
    wr(2, 32'd20);
    for (int i = 0; i < 32; i++) begin
      wr(1, 32'hFFFF_FFE0 | 32'(i));
      check_all("R3 setvl imm");
    end

    // R5 immediate set-maximum
    wr(2, 32'd64);
    wr(0, 32'd64);
    for (int i = 31; i >= 0; i--) begin
      wr(3, 32'hABCD_EF00 | 32'(i));
      check_all("R5 setmvl imm");
    end

    // R6 group size, legal and illegal
    for (int n = 0; n <= 9; n++) begin
      wr(4, 32'(n));
      check_all("R6 subvl");
    end
    wr(4, 32'h8000_0002);
    check_all("R6 subvl high bit");
    wr(4, 32'd3);
    check_all("R6 err clears");

    // R7 and R8 whole-word loads
    wr(5, 32'hFFFF_FFFF);
    check_all("R7 R8 load all ones");
    wr(5, 32'h0000_0FC1);
    check_all("R7 vl truncated");
    wr(5, 32'hF5A5_A5A5);
    check_all("R8 rsvd dropped");
    lcg = 32'h1234_5678;
    for (int i = 0; i < 40; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      wr(5, lcg);
      check_all("R7 load pattern");
    end

    // R10 unused selectors
    wr(5, 32'h0312_3456);
    for (int s = 6; s <= 7; s++) begin
      wr(s, 32'hFFFF_FFFF);
      check_all("R10 unused selector");
    end

    // R9 swap behaviour, with a colliding write discarded
    wr(5, 32'h0A1B_2C3F);
    trap(0, 1);
    check_all("R9 trap entry");
    wr(5, 32'h0500_0145);
    wr(0, 32'd3);
    check_all("R9 handler context");
    trap(1, 0);
    check_all("R9 trap return");
    trap(0, 0);
    check_all("R9 second entry");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule